// File: doc/BRIEF.md
# EPROM Byte Programming Sequencer

This controller writes an image into an ultraviolet-erasable EPROM one byte at a time. It walks every address of the array in rising order and fetches each target byte from a ready/valid byte stream. Before any pulse it reads the cell back once. It refuses a byte that would need a 0 turned back into a 1, and it skips a byte that already holds its target. Otherwise it drives address and data with chip enable low, fires a timed program strobe, releases the data bus and reads the byte back under output enable. It repeats strobe and readback until the byte matches or a fixed number of pulses has been spent. It never adds an extra pulse once a byte verifies.

After the last address it runs two whole-array verify passes, first at a raised supply level and then at a lowered one. Each pass pulls the same image again from the byte stream, in address order. Supply changes are requested from an external supply controller through a four-phase request/acknowledge handshake, and no read happens while a change is pending. All timing windows are parameters expressed in clock cycles, so one build serves any clock rate. At the end the block reports either done, or fail together with the address where it stopped.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset, chip enable, output enable and program strobe are high (inactive), the data bus driver is off, no supply request is made, `vpp_on`, `done` and `fail` are low and `src_ready` is low.
- R2: The program strobe `mem_pgm_n` is low for exactly PULSE_CYC cycles per pulse, only while chip enable is low, the data driver is on and `vpp_on` is high. For at least SETUP_CYC cycles before the strobe falls, address, data and chip enable are stable with the driver on, and the address does not move while the strobe is low.
- R3: After the strobe rises, the data driver stays on for at least HOLD_CYC cycles. Output enable falls at least OES_CYC cycles after the driver turns off, and the driver and output enable are never active together.
- R4: A readback is taken after output enable has been low for READ_CYC cycles. When the byte equals its target the sequencer moves to the next address, so every byte gets exactly as many pulses as the cell needs and no more.
- R5: The pulse counter restarts for each byte. When MAX_TRIES pulses have all failed verify, the run ends with `fail` high and `fail_addr` equal to that address, after exactly MAX_TRIES pulses on it.
- R6: Before any pulse, a byte whose current content has a 0 where the target has a 1 ends the run with `fail` and its address and receives no pulse. A byte whose current content already equals the target receives no pulse.
- R7: Supply levels are coded on `supply_sel` as 0 = programming level, 1 = raised verify level, 2 = lowered verify level. `supply_req` stays high with `supply_sel` steady until `supply_ack` rises, then drops. The sequencer waits for `supply_ack` to fall before continuing, and output enable stays high whenever `supply_req` or `supply_ack` is high.
- R8: A run requests levels 0, 1, 2 in that order. It programs the whole array at level 0, then verifies every address at level 1 and then at level 2, fetching the image again in address order for each pass.
- R9: A mismatch in a verify pass ends the run with `fail` and that address. A mismatch at level 1 means level 2 is never requested.
- R10: A successful run ends with `done` high and `fail` low. `done` and `fail` are never high together, stay unchanged until the next `start`, and after the run all memory controls are inactive and `vpp_on` is low.
- R11: One stream byte is consumed per address visit, on a cycle where `src_valid` and `src_ready` are both high. Gaps in `src_valid` only stall the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| src_data | input | 8 | Image byte from the stream |
| src_valid | input | 1 | Stream byte valid |
| src_ready | output | 1 | Sequencer accepts a stream byte |
| mem_addr | output | ADDR_W | Array address |
| mem_dout | output | 8 | Data driven to the array |
| mem_dout_en | output | 1 | Data bus driver enable |
| mem_din | input | 8 | Data read from the array |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_on | output | 1 | High-voltage programming supply request |
| supply_sel | output | 2 | Requested supply level code |
| supply_req | output | 1 | Supply change request |
| supply_ack | input | 1 | Supply change acknowledge |
| done | output | 1 | Run finished successfully |
| fail | output | 1 | Run aborted |
| fail_addr | output | ADDR_W | Address at which the run aborted |

## Verification
The assertions watch, on every cycle, the electrical rules at the memory pins: strobe width, strobe only with enable, driver and supply, no bus fight, a frozen address during the strobe, no read during a supply change, a steady level code while a request is open, and the bound on the pulse counter. What only scenarios can show is the outcome of a whole run against a behavioural array model. That means the pulse count each byte receives, the refusal of unwritable bytes, a retry-limit abort at the last address, verify failures that appear only at one supply level, the order of requested levels, and the number of stream bytes consumed before done or fail.

// File: rtl/eprom_prog_pkg.sv
// Shared types for the EPROM programming sequencer.
// Assumes: three supply levels, coded as the values the supply controller decodes.
package eprom_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SUP_REQ,
        ST_SUP_REL,
        ST_FETCH,
        ST_PRE_RD,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RELEASE,
        ST_VERIFY,
        ST_VF_FETCH,
        ST_VF_READ,
        ST_FINISH,
        ST_ABORT
    } seq_state_e;

    typedef enum logic [1:0] {
        PASS_PROG = 2'd0,
        PASS_HI   = 2'd1,
        PASS_LO   = 2'd2
    } pass_e;

    // Supply level code requested for a given pass.
    function automatic logic [1:0] pass_level(input pass_e p);
        return logic'(p == PASS_PROG) ? 2'd0 : (p == PASS_HI) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/eprom_phase_timer.sv
// Down-counter that times one phase of the memory cycle.
// Loading a value N-1 makes the phase last N cycles; zero is high on the last one.
// Assumes: load is only raised on the cycle a phase is entered.
module eprom_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt;

    // Load a new phase length or count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    a_r2_timer_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/eprom_addr_walk.sv
// Address walker: steps through the full array in rising order.
// Assumes: the array spans all 2**ADDR_W addresses.
module eprom_addr_walk #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    // Clear to the first address or advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr <= '0;
        else if (clr)   addr <= '0;
        else if (inc)   addr <= addr + 1'b1;
    end

    assign last = (addr == {ADDR_W{1'b1}});

    a_r8_addr_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/eprom_try_count.sv
// Per-byte pulse counter; last_try is high while the final allowed pulse is being verified.
// Assumes: inc is only raised after a failed verify that was not the last allowed one.
module eprom_try_count #(
    parameter int MAX_TRIES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_try
);

    localparam int CW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES - 1);

    logic [CW-1:0] cnt;

    // Restart at zero for each byte, step once per failed verify.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (inc)   cnt <= cnt + 1'b1;
    end

    assign last_try = (cnt == LIMIT);

    a_r5_tries_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);
    a_r5_no_step_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last_try);

endmodule

// File: rtl/eprom_prog_seq.sv
// EPROM byte programming sequencer (top).
// Programs the whole array with per-byte pulse-and-verify, then verifies every byte
// at a raised and at a lowered supply level, re-reading the image from the stream.
// Assumes: all timing parameters are >= 1 cycle; the image stream repeats the same
// bytes in address order for each of the three passes; the supply controller
// completes a four-phase req/ack handshake.
module eprom_prog_seq
    import eprom_prog_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int MAX_TRIES = 25,
    parameter int SETUP_CYC = 250,
    parameter int PULSE_CYC = 12500,
    parameter int HOLD_CYC  = 250,
    parameter int OES_CYC   = 250,
    parameter int READ_CYC  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        src_data,
    input  logic              src_valid,
    output logic              src_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_dout,
    output logic              mem_dout_en,
    input  logic [7:0]        mem_din,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_pgm_n,
    output logic              vpp_on,
    output logic [1:0]        supply_sel,
    output logic              supply_req,
    input  logic              supply_ack,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);

    localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_B   = (HOLD_CYC > OES_CYC) ? HOLD_CYC : OES_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > READ_CYC) ? MAX_C : READ_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] SU_V = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PW_V = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HD_V = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] OE_V = CNT_W'(OES_CYC - 1);
    localparam logic [CNT_W-1:0] RD_V = CNT_W'(READ_CYC - 1);

    seq_state_e       st, st_n;
    pass_e            pass_q, pass_n;
    logic [7:0]       tgt;
    logic             cap_tgt;
    logic             t_load, t_zero;
    logic [CNT_W-1:0] t_val;
    logic             a_clr, a_inc, a_last;
    logic             k_clr, k_inc, k_last;

    eprom_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    eprom_addr_walk #(.ADDR_W(ADDR_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr(a_clr), .inc(a_inc),
        .addr(mem_addr), .last(a_last)
    );

    eprom_try_count #(.MAX_TRIES(MAX_TRIES)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(k_clr), .inc(k_inc), .last_try(k_last)
    );

    // Next-state and control strobes of the programming/verify sequence.
    always_comb begin
        st_n    = st;
        pass_n  = pass_q;
        t_load  = 1'b0;
        t_val   = '0;
        a_clr   = 1'b0;
        a_inc   = 1'b0;
        k_clr   = 1'b0;
        k_inc   = 1'b0;
        cap_tgt = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    pass_n = PASS_PROG;
                    a_clr  = 1'b1;
                    st_n   = ST_SUP_REQ;
                end
            end
            ST_SUP_REQ: begin
                if (supply_ack) st_n = ST_SUP_REL;
            end
            ST_SUP_REL: begin
                if (!supply_ack) begin
                    a_clr = 1'b1;
                    st_n  = (pass_q == PASS_PROG) ? ST_FETCH : ST_VF_FETCH;
                end
            end
            ST_FETCH: begin
                if (src_valid) begin
                    cap_tgt = 1'b1;
                    k_clr   = 1'b1;
                    t_load  = 1'b1;
                    t_val   = RD_V;
                    st_n    = ST_PRE_RD;
                end
            end
            ST_PRE_RD: begin
                if (t_zero) begin
                    if ((mem_din & tgt) != tgt) begin
                        st_n = ST_ABORT;
                    end else if (mem_din == tgt) begin
                        if (a_last) begin
                            pass_n = PASS_HI;
                            st_n   = ST_SUP_REQ;
                        end else begin
                            a_inc = 1'b1;
                            st_n  = ST_FETCH;
                        end
                    end else begin
                        t_load = 1'b1;
                        t_val  = SU_V;
                        st_n   = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    t_val  = PW_V;
                    st_n   = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    t_val  = HD_V;
                    st_n   = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    t_val  = OE_V;
                    st_n   = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (t_zero) begin
                    t_load = 1'b1;
                    t_val  = RD_V;
                    st_n   = ST_VERIFY;
                end
            end
            ST_VERIFY: begin
                if (t_zero) begin
                    if (mem_din == tgt) begin
                        if (a_last) begin
                            pass_n = PASS_HI;
                            st_n   = ST_SUP_REQ;
                        end else begin
                            a_inc = 1'b1;
                            st_n  = ST_FETCH;
                        end
                    end else if (k_last) begin
                        st_n = ST_ABORT;
                    end else begin
                        k_inc  = 1'b1;
                        t_load = 1'b1;
                        t_val  = SU_V;
                        st_n   = ST_SETUP;
                    end
                end
            end
            ST_VF_FETCH: begin
                if (src_valid) begin
                    cap_tgt = 1'b1;
                    t_load  = 1'b1;
                    t_val   = RD_V;
                    st_n    = ST_VF_READ;
                end
            end
            ST_VF_READ: begin
                if (t_zero) begin
                    if (mem_din != tgt) begin
                        st_n = ST_ABORT;
                    end else if (a_last) begin
                        if (pass_q == PASS_HI) begin
                            pass_n = PASS_LO;
                            st_n   = ST_SUP_REQ;
                        end else begin
                            st_n = ST_FINISH;
                        end
                    end else begin
                        a_inc = 1'b1;
                        st_n  = ST_VF_FETCH;
                    end
                end
            end
            ST_FINISH: st_n = ST_IDLE;
            ST_ABORT:  st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // State, pass and target byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            pass_q <= PASS_PROG;
            tgt    <= '0;
        end else begin
            st     <= st_n;
            pass_q <= pass_n;
            if (cap_tgt) tgt <= src_data;
        end
    end

    // Result flags and failing address, held until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
        end else if (st == ST_IDLE && start) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (st == ST_FINISH) begin
            done <= 1'b1;
        end else if (st == ST_ABORT) begin
            fail      <= 1'b1;
            fail_addr <= mem_addr;
        end
    end

    // Memory pin decode from the current state.
    always_comb begin
        mem_ce_n    = !(st inside {ST_PRE_RD, ST_SETUP, ST_PULSE, ST_HOLD,
                                   ST_RELEASE, ST_VERIFY, ST_VF_READ});
        mem_oe_n    = !(st inside {ST_PRE_RD, ST_VERIFY, ST_VF_READ});
        mem_pgm_n   = (st != ST_PULSE);
        mem_dout_en = (st inside {ST_SETUP, ST_PULSE, ST_HOLD});
    end

    assign mem_dout   = tgt;
    assign src_ready  = (st == ST_FETCH) || (st == ST_VF_FETCH);
    assign supply_req = (st == ST_SUP_REQ);
    assign supply_sel = pass_level(pass_q);
    assign vpp_on     = !(st inside {ST_IDLE, ST_FINISH, ST_ABORT});

    // Strobe-width counter used only by the width assertion.
    logic [CNT_W:0] pw_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)          pw_cnt <= '0;
        else if (!mem_pgm_n) pw_cnt <= pw_cnt + 1'b1;
        else                 pw_cnt <= '0;
    end

    a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_pgm_n && !$past(mem_pgm_n)) |-> (pw_cnt == (CNT_W+1)'(PULSE_CYC)));
    a_r2_pulse_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |-> (!mem_ce_n && mem_dout_en && vpp_on && mem_oe_n));
    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |=> $stable(mem_addr));
    a_r3_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dout_en && !mem_oe_n));
    a_r7_no_read_in_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_req || supply_ack) |-> mem_oe_n);
    a_r7_level_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_req && $past(supply_req)) |-> $stable(supply_sel));
    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fail}));

endmodule

// File: tb/eprom_prog_seq_test.sv
module eprom_prog_seq_test;

    localparam int AW    = 4;
    localparam int DEPTH = 16;
    localparam int MAXT  = 25;
    localparam int SU    = 4;
    localparam int PW    = 20;
    localparam int HD    = 3;
    localparam int OES   = 3;
    localparam int RD    = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [7:0]    src_data = 8'h00;
    logic          src_valid = 1'b0;
    logic          src_ready;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dout;
    logic          mem_dout_en;
    logic [7:0]    mem_din;
    logic          mem_ce_n, mem_oe_n, mem_pgm_n, vpp_on;
    logic [1:0]    supply_sel;
    logic          supply_req;
    logic          supply_ack = 1'b0;
    logic          done, fail;
    logic [AW-1:0] fail_addr;

    always #4 clk = ~clk;

    eprom_prog_seq #(
        .ADDR_W(AW), .MAX_TRIES(MAXT), .SETUP_CYC(SU), .PULSE_CYC(PW),
        .HOLD_CYC(HD), .OES_CYC(OES), .READ_CYC(RD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data),
        .src_valid(src_valid), .src_ready(src_ready), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .vpp_on(vpp_on), .supply_sel(supply_sel), .supply_req(supply_req),
        .supply_ack(supply_ack), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    // Scenario set-up (written by the initial block only)
    logic [7:0] image [DEPTH];
    logic [7:0] pre   [DEPTH];
    int         need  [DEPTH];
    int         weak_addr = -1;
    int         weak_lvl  = -1;
    logic       model_clear = 1'b0;
    logic       stream_en   = 1'b0;
    int         hs_base = 0;

    // Model state (written by the negedge model only)
    logic [7:0] mem    [DEPTH];
    int         pulses [DEPTH];
    int         lev_log [8];
    int         lev_n = 0;
    logic [1:0] cur_lvl = 2'd0;
    int         sup_dly = 0;
    int         viol_r2 = 0, viol_r3 = 0, viol_r7 = 0;
    int         su_cnt = 0, lo_cnt = 0, hd_cnt = 0, rel_cnt = 1000;
    logic       p_pgm = 1'b1, p_oe = 1'b1, p_doe = 1'b0;
    logic [AW-1:0] p_addr = '0;
    int         hs_cnt = 0;

    int nchk = 0, nerr = 0;

    // Read model: weak byte flips a bit at one supply level
    assign mem_din = (!mem_ce_n && !mem_oe_n)
        ? (mem[mem_addr] ^ (((int'(mem_addr) == weak_addr) && (int'(cur_lvl) == weak_lvl)) ? 8'h10 : 8'h00))
        : 8'hFF;

    always @(posedge clk) begin
        if (src_valid && src_ready) hs_cnt <= hs_cnt + 1;
    end

    // Array, supply and stream models plus pin-timing monitors, away from the active edge
    always @(negedge clk) begin
        if (model_clear) begin
            for (int a = 0; a < DEPTH; a++) begin
                mem[a] = pre[a];
                pulses[a] = 0;
            end
            lev_n = 0;
        end
        // program pulse applied on strobe fall
        if (p_pgm && !mem_pgm_n && !mem_ce_n) begin
            pulses[mem_addr] = pulses[mem_addr] + 1;
            if (pulses[mem_addr] >= need[mem_addr]) mem[mem_addr] = mem[mem_addr] & mem_dout;
        end
        // timing checks (old counters first)
        if (p_pgm && !mem_pgm_n && su_cnt < SU) viol_r2++;
        if (!p_pgm && mem_pgm_n && lo_cnt != PW) viol_r2++;
        if (p_doe && !mem_dout_en && hd_cnt < HD) viol_r3++;
        if (p_oe && !mem_oe_n && rel_cnt < OES) viol_r3++;
        if (mem_dout_en && !mem_oe_n) viol_r3++;
        if (!mem_oe_n && (supply_req || supply_ack)) viol_r7++;
        // counter updates
        if (mem_dout_en && !mem_ce_n && mem_pgm_n && mem_addr == p_addr) su_cnt++;
        else su_cnt = 0;
        if (!mem_pgm_n) lo_cnt++; else lo_cnt = 0;
        if (!p_pgm && mem_pgm_n) hd_cnt = 1;
        else if (mem_pgm_n && mem_dout_en) hd_cnt++;
        if (p_doe && !mem_dout_en) rel_cnt = 1;
        else if (rel_cnt < 1000) rel_cnt++;
        p_pgm = mem_pgm_n; p_oe = mem_oe_n; p_doe = mem_dout_en; p_addr = mem_addr;
        // supply controller
        if (supply_req && !supply_ack) begin
            sup_dly++;
            if (sup_dly == 3) begin
                sup_dly = 0;
                supply_ack = 1'b1;
                cur_lvl = supply_sel;
                if (lev_n < 8) lev_log[lev_n] = int'(supply_sel);
                lev_n++;
            end
        end else if (!supply_req && supply_ack) begin
            supply_ack = 1'b0;
        end
        // stream source with random gaps
        src_valid = stream_en && (($urandom % 4) != 0);
        src_data  = image[(hs_cnt - hs_base) % DEPTH];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected results
    int exp_fail, exp_addr, exp_hs, exp_nlev;
    int exp_pulses [DEPTH];
    logic [7:0] exp_mem [DEPTH];

    task automatic predict();
        exp_fail = 0; exp_addr = 0;
        for (int a = 0; a < DEPTH; a++) begin
            exp_mem[a] = pre[a];
            exp_pulses[a] = 0;
            if (exp_fail == 0) begin
                if ((pre[a] & image[a]) != image[a]) begin
                    exp_fail = 1; exp_addr = a;
                end else if (pre[a] != image[a]) begin
                    if (need[a] > MAXT) begin
                        exp_fail = 1; exp_addr = a; exp_pulses[a] = MAXT;
                    end else begin
                        exp_pulses[a] = need[a];
                        exp_mem[a] = pre[a] & image[a];
                    end
                end
            end
        end
        if (exp_fail != 0) begin
            exp_hs = exp_addr + 1; exp_nlev = 1;
        end else if (weak_lvl == 1) begin
            exp_fail = 1; exp_addr = weak_addr; exp_hs = DEPTH + weak_addr + 1; exp_nlev = 2;
        end else if (weak_lvl == 2) begin
            exp_fail = 1; exp_addr = weak_addr; exp_hs = 2*DEPTH + weak_addr + 1; exp_nlev = 3;
        end else begin
            exp_hs = 3*DEPTH; exp_nlev = 3;
        end
    endtask

    task automatic run_scn(input string name);
        int b2, b3, b7, bad, first, cyc;
        bit hit;
        model_clear = 1'b1;
        @(negedge clk); #1;
        model_clear = 1'b0;
        predict();
        hs_base = hs_cnt;
        b2 = viol_r2; b3 = viol_r3; b7 = viol_r7;
        stream_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hit = 0;
        for (cyc = 0; cyc < 40000; cyc++) begin
            @(negedge clk);
            if (done || fail) begin hit = 1; break; end
        end
        stream_en = 1'b0;
        check(hit, "R10", {name, " watchdog"}, cyc, 0);
        check(int'(fail) == exp_fail, exp_fail ? "R5" : "R10", {name, " fail flag"}, int'(fail), exp_fail);
        check(int'(done) == 1 - exp_fail, "R10", {name, " done flag"}, int'(done), 1 - exp_fail);
        if (exp_fail != 0)
            check(int'(fail_addr) == exp_addr, "R9", {name, " fail_addr"}, int'(fail_addr), exp_addr);
        bad = 0; first = -1;
        for (int a = 0; a < DEPTH; a++)
            if (pulses[a] != exp_pulses[a]) begin bad++; if (first < 0) first = a; end
        check(bad == 0, "R4", {name, " pulse count first bad addr"},
              (first < 0) ? 0 : pulses[first], (first < 0) ? 0 : exp_pulses[first]);
        bad = 0;
        for (int a = 0; a < DEPTH; a++) if (mem[a] != exp_mem[a]) bad++;
        check(bad == 0, "R4", {name, " array content mismatches"}, bad, 0);
        check(lev_n == exp_nlev, "R8", {name, " levels requested"}, lev_n, exp_nlev);
        bad = 0;
        for (int i = 0; i < lev_n && i < 8; i++) if (lev_log[i] != i) bad++;
        check(bad == 0, "R7", {name, " level order errors"}, bad, 0);
        check(hs_cnt - hs_base == exp_hs, "R11", {name, " stream bytes consumed"}, hs_cnt - hs_base, exp_hs);
        check(viol_r2 == b2, "R2", {name, " strobe timing violations"}, viol_r2 - b2, 0);
        check(viol_r3 == b3, "R3", {name, " hold/release violations"}, viol_r3 - b3, 0);
        check(viol_r7 == b7, "R7", {name, " reads during supply change"}, viol_r7 - b7, 0);
        check(mem_ce_n && mem_oe_n && mem_pgm_n && !mem_dout_en && !vpp_on && !supply_req,
              "R10", {name, " idle pins after run"},
              {mem_ce_n, mem_oe_n, mem_pgm_n, mem_dout_en, vpp_on, supply_req}, 6'b111000);
    endtask

    task automatic fill_random(input int pmode);
        for (int a = 0; a < DEPTH; a++) begin
            image[a] = 8'($urandom);
            need[a]  = 1 + ($urandom % 4);
            case (pmode)
                0: pre[a] = 8'hFF;
                default: begin
                    case ($urandom % 3)
                        0: pre[a] = image[a];
                        1: pre[a] = image[a] | 8'($urandom);
                        default: pre[a] = 8'hFF;
                    endcase
                end
            endcase
        end
        weak_addr = -1; weak_lvl = -1;
    endtask

    initial begin
        int k;
        void'($urandom(32'h00C0FFEE));
        for (int a = 0; a < DEPTH; a++) begin
            image[a] = 8'hFF; pre[a] = 8'hFF; need[a] = 1;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(mem_ce_n && mem_oe_n && mem_pgm_n && !mem_dout_en && !supply_req &&
              !vpp_on && !done && !fail && !src_ready, "R1", "reset outputs",
              {mem_ce_n, mem_oe_n, mem_pgm_n, mem_dout_en, supply_req, vpp_on, done, fail, src_ready},
              9'b111000000);
        rst_n = 1'b1;
        @(negedge clk);

        // S1: erased array, random image and cell strength
        fill_random(0);
        run_scn("erased");
        repeat (6) @(negedge clk);
        check(done && !fail, "R10", "done held while idle", int'(done), 1);

        // S2: partly programmed array, some bytes already at target (R6 skip)
        fill_random(1);
        run_scn("preloaded");

        // S3: R5 retry limit in mid-array
        fill_random(0);
        k = 3 + ($urandom % 10);
        image[k] = 8'h5A; need[k] = 30;
        run_scn("retry_limit");

        // S4: R6 unwritable byte gets no pulse
        fill_random(0);
        k = 2 + ($urandom % 12);
        image[k] = 8'($urandom) | 8'h01; pre[k] = 8'hFE;
        run_scn("unwritable");
        check(pulses[k] == 0, "R6", "pulses on unwritable byte", pulses[k], 0);

        // S5: R9 failure only at the lowered level
        fill_random(0);
        weak_addr = $urandom % DEPTH; weak_lvl = 2;
        run_scn("weak_low");

        // S6: R9 failure at the raised level, lowered level never requested
        fill_random(0);
        weak_addr = $urandom % DEPTH; weak_lvl = 1;
        run_scn("weak_high");
        check(lev_n == 2, "R9", "levels after raised-level failure", lev_n, 2);

        // S7: R5 retry limit at the last address
        fill_random(0);
        image[DEPTH-1] = 8'h00; need[DEPTH-1] = 30;
        run_scn("last_addr_limit");

        // S8: all-zero image, single pulse per byte, after a failed run
        for (int a = 0; a < DEPTH; a++) begin
            image[a] = 8'h00; pre[a] = 8'hFF; need[a] = 1;
        end
        weak_addr = -1; weak_lvl = -1;
        run_scn("all_zero");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule